// File: doc/BRIEF.md
# Phase-Split Three-Port Register File

This block is a register file for a pipelined core that needs two operands read and one result written in every system cycle. Its storage array can serve only one kind of access per clock edge: two independent single-ended reads, or one write. To get three logical ports out of it, each system cycle is cut into two phases, each lasting one edge of a double-rate clock. A read phase serves both read ports. A write phase then commits the write port.

The surrounding logic drives `clk` at twice the system rate and marks the phases with `phase_wr`. A low value selects the read phase and a high value selects the write phase, and the two alternate. Read addresses are taken at the read-phase edge. The operands are registered there and held through the write phase. Write address, data and enable are taken at the write-phase edge. Because the read phase comes first, a read and a write of the same entry in one cycle return the old contents. Entry 0 is hard-wired to zero.

Top module: `rfp_regfile`

## Requirements
- R1: The file holds 32 entries of 32 bits; the two read ports return the stored contents of their own, independent addresses.
- R2: Read data is captured at a clock edge where `phase_wr` is 0 and held unchanged across the following edge where `phase_wr` is 1; read addresses presented during the write phase have no effect.
- R3: At an edge where `phase_wr` is 1 and `wr_en` is 1, `wr_data` is stored into entry `wr_addr`, driven as a true/complement pair, and is seen by reads of the next system cycle.
- R4: When a read and a write of the same entry fall in the same system cycle, the read returns the value from before the write.
- R5: Reading entry 0 always returns zero, and writes to entry 0 leave it zero.
- R6: `wr_en` asserted during the read phase (`phase_wr` = 0) changes no entry, and a write phase with `wr_en` = 0 changes no entry.
- R7: At any clock edge the storage array either performs the two reads or the single write, never both.
- R8: A synchronous active-low reset (`rst_n` = 0) clears both read data outputs to zero at the next edge and blocks writes while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, two edges per system cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_wr | input | 1 | Phase marker: 0 = read phase, 1 = write phase |
| rd_addr_a | input | 5 | Read address, port A |
| rd_addr_b | input | 5 | Read address, port B |
| rd_data_a | output | 32 | Registered read operand, port A |
| rd_data_b | output | 32 | Registered read operand, port B |
| wr_en | input | 1 | Write enable, honoured in the write phase only |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |

## Verification
A read and a write of the same entry can fall in one system cycle. The bench provokes this on purpose by giving a read port the same address that the write port targets in that cycle. The expected operand comes from a reference array that is updated only after the cycle's reads have been queued, so the old value is required. A read of that entry in the next cycle must then show the new value. Addresses are scrambled during the write phase to confirm that the captured operands hold.

// File: rtl/rfp_pkg.sv
// Package: shared definitions for the phase-split register file.
// Assumes: the phase marker is a single bit, low for the read phase.
package rfp_pkg;

    // Phase encoding seen on the phase marker input
    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    // Number of logical read ports served by one array access
    localparam int unsigned N_RD_PORTS = 2;

endpackage

// File: rtl/rfp_phase_ctrl.sv
// Module: rfp_phase_ctrl
// Turns the phase marker into mutually exclusive array strobes and drives
// the write data as a true/complement pair.
// Assumes: phase_wr alternates once per clock edge, supplied by the caller.
module rfp_phase_ctrl
    import rfp_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned ABITS = 5
) (
    input  logic             rst_n,
    input  logic             phase_wr,
    input  logic             wr_en,
    input  logic [ABITS-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic             arr_rd_en,
    output logic             arr_wr_en,
    output logic [WIDTH-1:0] bl,
    output logic [WIDTH-1:0] bl_n
);

    phase_e phase;

    // Decode the phase marker into its enum form
    always_comb phase = phase_e'(phase_wr);

    // Pick exactly one access kind for this edge
    always_comb begin
        arr_rd_en = rst_n && (phase == PH_READ);
        arr_wr_en = rst_n && (phase == PH_WRITE) && wr_en && (wr_addr != '0);
    end

    // Drive both polarities of the write data onto the bit lines
    always_comb begin
        bl   = wr_data;
        bl_n = ~wr_data;
    end

endmodule

// File: rtl/rfp_row_decoder.sv
// Module: rfp_row_decoder
// One-hot word-line decoder for the write access; row 0 never fires.
// Assumes: the write strobe already excludes address zero and the read phase.
module rfp_row_decoder #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned ABITS = 5
) (
    input  logic             wr_strobe,
    input  logic [ABITS-1:0] wr_addr,
    output logic [DEPTH-1:0] row_we
);

    // Row 0 has no storage, so its word line stays low
    assign row_we[0] = 1'b0;

    for (genvar r = 1; r < DEPTH; r++) begin : g_row
        // One address comparator per row word line
        assign row_we[r] = wr_strobe && (wr_addr == ABITS'(r));
    end

endmodule

// File: rtl/rfp_cell_array.sv
// Module: rfp_cell_array
// Storage rows 1..DEPTH-1; row 0 reads as constant zero.
// A row updates only when its word line is high and the two bit-line
// polarities disagree on every bit, as a differential write requires.
// Assumes: at most one word line is high per edge.
module rfp_cell_array #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32
) (
    input  logic                         clk,
    input  logic [DEPTH-1:0]             row_we,
    input  logic [WIDTH-1:0]             bl,
    input  logic [WIDTH-1:0]             bl_n,
    output logic [DEPTH-1:0][WIDTH-1:0]  cells
);

    logic [DEPTH-1:0][WIDTH-1:0] store_q;
    logic                        drive_ok;

    // A valid differential drive has every bit pair complementary
    always_comb drive_ok = ((bl ^ bl_n) == {WIDTH{1'b1}});

    // Commit the bit-line value into the selected row
    always_ff @(posedge clk) begin
        for (int r = 1; r < DEPTH; r++) begin
            if (row_we[r] && drive_ok) begin
                store_q[r] <= bl;
            end
        end
    end

    // Present the rows to the read ports with row 0 forced to zero
    always_comb begin
        cells    = store_q;
        cells[0] = '0;
    end

endmodule

// File: rtl/rfp_read_port.sv
// Module: rfp_read_port
// One single-ended read port: selects a row and registers it at the
// read-phase edge, holding the value through the write phase.
// Assumes: rd_strobe is low whenever the array is being written.
module rfp_read_port #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned ABITS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_strobe,
    input  logic [ABITS-1:0]            rd_addr,
    input  logic [DEPTH-1:0][WIDTH-1:0] cells,
    output logic [WIDTH-1:0]            rd_data
);

    logic [WIDTH-1:0] sel_val;
    logic [WIDTH-1:0] data_q;

    // Column select for the addressed row
    always_comb sel_val = cells[rd_addr];

    // Capture the operand at the read-phase edge, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_strobe) begin
            data_q <= sel_val;
        end
    end

    assign rd_data = data_q;

endmodule

// File: rtl/rfp_regfile.sv
// Module: rfp_regfile (top)
// Register file giving two reads and one write per system cycle from an
// array that does one access kind per edge: reads on the read-phase edge,
// the write on the following write-phase edge.
// Assumes: clk runs at twice the system rate; phase_wr alternates 0,1.
module rfp_regfile
    import rfp_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned ABITS = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_wr,
    input  logic [ABITS-1:0] rd_addr_a,
    input  logic [ABITS-1:0] rd_addr_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic             wr_en,
    input  logic [ABITS-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic                        arr_rd_en;
    logic                        arr_wr_en;
    logic [WIDTH-1:0]            bl;
    logic [WIDTH-1:0]            bl_n;
    logic [DEPTH-1:0]            row_we;
    logic [DEPTH-1:0][WIDTH-1:0] cells;
    logic [ABITS-1:0]            port_addr [N_RD_PORTS];
    logic [WIDTH-1:0]            port_data [N_RD_PORTS];

    rfp_phase_ctrl #(.WIDTH(WIDTH), .ABITS(ABITS)) u_phase (
        .rst_n     (rst_n),
        .phase_wr  (phase_wr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .arr_rd_en (arr_rd_en),
        .arr_wr_en (arr_wr_en),
        .bl        (bl),
        .bl_n      (bl_n)
    );

    rfp_row_decoder #(.DEPTH(DEPTH), .ABITS(ABITS)) u_dec (
        .wr_strobe (arr_wr_en),
        .wr_addr   (wr_addr),
        .row_we    (row_we)
    );

    rfp_cell_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
        .clk    (clk),
        .row_we (row_we),
        .bl     (bl),
        .bl_n   (bl_n),
        .cells  (cells)
    );

    // Gather the read addresses so the ports can be generated
    assign port_addr[0] = rd_addr_a;
    assign port_addr[1] = rd_addr_b;

    for (genvar p = 0; p < N_RD_PORTS; p++) begin : g_rd
        rfp_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ABITS(ABITS)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_strobe (arr_rd_en),
            .rd_addr   (port_addr[p]),
            .cells     (cells),
            .rd_data   (port_data[p])
        );
    end

    assign rd_data_a = port_data[0];
    assign rd_data_b = port_data[1];

endmodule

// File: rtl/rfp_checker.sv
// Module: rfp_checker
// Temporal checks on the register file, bound into every instance.
// Assumes: same parameters as the bound top.
module rfp_checker #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned ABITS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_wr,
    input logic [ABITS-1:0] rd_addr_a,
    input logic [ABITS-1:0] rd_addr_b,
    input logic [WIDTH-1:0] rd_data_a,
    input logic [WIDTH-1:0] rd_data_b,
    input logic             arr_rd_en,
    input logic             arr_wr_en,
    input logic [WIDTH-1:0] bl,
    input logic [WIDTH-1:0] bl_n,
    input logic [DEPTH-1:0] row_we
);

    // R7: the array never reads and writes at the same edge
    a_r7_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_en && arr_wr_en));

    // R7: at most one word line per edge
    a_r7_onehot_rows: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_we));

    // R2: operands do not move across a write-phase edge
    a_r2_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        phase_wr |=> $stable(rd_data_a));
    a_r2_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        phase_wr |=> $stable(rd_data_b));

    // R6: no write strobe during the read phase
    a_r6_no_read_phase_write: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_wr |-> !arr_wr_en);

    // R3: a write drives complementary bit lines
    a_r3_diff_drive: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (bl_n == ~bl));

    // R5: entry 0 always reads as zero
    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_wr && rd_addr_a == '0) |=> (rd_data_a == '0));
    a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_wr && rd_addr_b == '0) |=> (rd_data_b == '0));

    // R8: reset clears both operands
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (rd_data_a == '0 && rd_data_b == '0));

endmodule

bind rfp_regfile rfp_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ABITS(ABITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_wr  (phase_wr),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .arr_rd_en (arr_rd_en),
    .arr_wr_en (arr_wr_en),
    .bl        (bl),
    .bl_n      (bl_n),
    .row_we    (row_we)
);

// File: tb/rfp_regfile_test.sv
// Scoreboard bench: the driver queues expected operands per system cycle,
// the monitor pops and compares them after each read-phase edge.
module rfp_regfile_test;

    localparam int unsigned DEPTH = 32;
    localparam int unsigned WIDTH = 32;
    localparam int unsigned ABITS = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             phase_wr = 1'b1;
    logic [ABITS-1:0] rd_addr_a = '0;
    logic [ABITS-1:0] rd_addr_b = '0;
    logic [WIDTH-1:0] rd_data_a;
    logic [WIDTH-1:0] rd_data_b;
    logic             wr_en = 1'b0;
    logic [ABITS-1:0] wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;

    int unsigned errors = 0;
    int unsigned checks = 0;
    bit          done = 1'b0;

    logic [WIDTH-1:0] ref_mem [DEPTH];
    logic [WIDTH-1:0] exp_a_q [$];
    logic [WIDTH-1:0] exp_b_q [$];
    string            tag_q [$];
    logic [WIDTH-1:0] last_a, last_b;
    bit               have_last = 1'b0;

    rfp_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_wr  (phase_wr),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One system cycle: read phase then write phase
    task automatic sys_cycle(input logic [ABITS-1:0] ra, input logic [ABITS-1:0] rb,
                             input logic we, input logic [ABITS-1:0] wa,
                             input logic [WIDTH-1:0] wd, input string tag,
                             input logic rp_we = 1'b0);
        @(negedge clk);
        phase_wr  = 1'b0;
        rd_addr_a = ra;
        rd_addr_b = rb;
        wr_en     = rp_we;
        wr_addr   = wa;
        wr_data   = ~wd;
        exp_a_q.push_back(ref_mem[ra]);
        exp_b_q.push_back(ref_mem[rb]);
        tag_q.push_back(tag);
        @(negedge clk);
        phase_wr  = 1'b1;
        rd_addr_a = ra ^ 5'h15;
        rd_addr_b = rb ^ 5'h0A;
        wr_en     = we;
        wr_addr   = wa;
        wr_data   = wd;
        if (we && wa != '0) ref_mem[wa] = wd;
    endtask

    // Monitor: compare after read edges, confirm hold after write edges
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!phase_wr && exp_a_q.size() > 0) begin
                string t;
                logic [WIDTH-1:0] ea, eb;
                t  = tag_q.pop_front();
                ea = exp_a_q.pop_front();
                eb = exp_b_q.pop_front();
                check({t, " port A"}, rd_data_a, ea);
                check({t, " port B"}, rd_data_b, eb);
                last_a    = rd_data_a;
                last_b    = rd_data_b;
                have_last = 1'b1;
            end else if (phase_wr && have_last && rst_n) begin
                check("R2 hold A", rd_data_a, last_a);
                check("R2 hold B", rd_data_b, last_b);
                have_last = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        // R8: reset clears the outputs
        repeat (4) begin
            @(negedge clk);
            phase_wr = ~phase_wr;
        end
        @(negedge clk);
        check("R8 reset A", rd_data_a, '0);
        check("R8 reset B", rd_data_b, '0);
        rst_n = 1'b1;
        phase_wr = 1'b1;

        // R1/R3: fill every entry while reading entry 0 (R5)
        for (int k = 1; k < DEPTH; k++)
            sys_cycle(5'd0, 5'd0, 1'b1, ABITS'(k), 32'hA5000000 ^ (32'(k) * 32'h01010101), "R5 zero fill");

        // R1: independent readback of every entry
        for (int k = 1; k < DEPTH; k++)
            sys_cycle(ABITS'(k), ABITS'(DEPTH - k), 1'b0, '0, '0, "R1 readback");

        // R4: same-address read and write in one cycle gives old value
        sys_cycle(5'd7, 5'd9, 1'b1, 5'd7, 32'hDEADBEEF, "R4 same cycle old");
        sys_cycle(5'd9, 5'd7, 1'b1, 5'd9, 32'h12345678, "R3 new visible");
        sys_cycle(5'd9, 5'd9, 1'b0, '0, '0, "R3 new visible");

        // R5: write to entry 0 ignored
        sys_cycle(5'd0, 5'd3, 1'b1, 5'd0, 32'hFFFFFFFF, "R5 write zero");
        sys_cycle(5'd0, 5'd0, 1'b0, '0, '0, "R5 zero after write");

        // R6: write enable in read phase only, and write phase with enable low
        sys_cycle(5'd4, 5'd5, 1'b0, 5'd4, 32'h0BADF00D, "R6 read-phase enable", 1'b1);
        sys_cycle(5'd4, 5'd5, 1'b0, 5'd5, 32'h0BADF00D, "R6 no change");
        sys_cycle(5'd4, 5'd5, 1'b0, '0, '0, "R6 no change");

        // R1/R4 mixed random traffic
        for (int n = 0; n < 300; n++) begin
            logic [ABITS-1:0] ra, rb, wa;
            ra = ABITS'($urandom_range(0, DEPTH - 1));
            rb = ABITS'($urandom_range(0, DEPTH - 1));
            wa = (n % 4 == 0) ? ra : ABITS'($urandom_range(0, DEPTH - 1));
            sys_cycle(ra, rb, 1'($urandom_range(0, 1)), wa, $urandom, "R1 R4 random");
        end
        sys_cycle(5'd1, 5'd2, 1'b0, '0, '0, "R1 final");

        // R8: reset after live data clears the operands
        @(negedge clk);
        rst_n    = 1'b0;
        wr_en    = 1'b0;
        phase_wr = 1'b0;
        @(negedge clk);
        phase_wr = 1'b1;
        check("R8 mid-run reset A", rd_data_a, '0);
        check("R8 mid-run reset B", rd_data_b, '0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule